// File: doc/BRIEF.md
# Operate Unit with Condition Codes

This block is the arithmetic/logic execute stage of a small 16-bit load/store machine. It holds eight general-purpose registers. It accepts one instruction word per cycle, qualified by a valid strobe, and decodes it. Three operations are supported: two's-complement addition, bitwise AND and bitwise inversion. The first operand always comes from a register. For addition and AND, the second operand is either another register or a short signed constant carried in the instruction.

Each accepted instruction writes its result back into the register file at the clock edge that accepts it. The same write appears for one cycle on a registered write port: strobe, destination index and value. Three condition flags record the sign class of the last value written: negative, zero or positive. The flags keep that class until the next write. An instruction can therefore use the result of the one issued in the cycle before it, with no stall.

Top module: `operate_unit`

## Requirements
- R1: While reset is asserted and after it is released, the write strobe is low, every register holds zero, and the flags read negative=0, zero=1, positive=0.
- R2: The operation is chosen by instruction bits [15:12]: 4'b0001 is addition, 4'b0101 is AND, 4'b1001 is inversion. The destination index is bits [11:9] and the first source index is bits [8:6].
- R3: For addition and AND with bit 5 clear, the second operand is the register indexed by bits [2:0]. Bits [4:3] have no effect. Addition wraps modulo 2^16.
- R4: For addition and AND with bit 5 set, the second operand is bits [4:0] read as a two's-complement value and sign-extended to 16 bits.
- R5: AND writes the bitwise AND of its two operands.
- R6: Inversion writes the bitwise complement of the first source register, but only when bits [5:0] are all ones.
- R7: Each register write updates the flags. Negative is set when bit 15 of the written value is 1. Zero is set when the value is 0. Positive is set otherwise. Exactly one flag is set at all times.
- R8: An instruction with any other opcode, or an inversion whose bits [5:0] are not all ones, writes no register and leaves the flags unchanged.
- R9: While the valid strobe is low, no register is written and the flags do not change.
- R10: One cycle after a valid recognised instruction, the write strobe is high for one cycle with the destination index and result. The register file already holds that result for the next instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| instrValid | input | 1 | Instruction word is valid this cycle |
| instrWord | input | 16 | Instruction to execute |
| wrEn | output | 1 | Register write performed at the last edge |
| wrAddr | output | 3 | Destination register index of that write |
| wrData | output | 16 | Value written |
| flagN | output | 1 | Last written value was negative |
| flagZ | output | 1 | Last written value was zero |
| flagP | output | 1 | Last written value was positive |

## Verification
The register contents are visible only through the write port. The hardest case is confirming that a rejected instruction left a register and the flags untouched. The stimulus handles this by following each rejected, illegal or idle instruction with an add-zero of the register it could have disturbed, which copies that register's value onto the write port. A second difficult case is the edge between adjacent instructions, where a result must be forwarded through the register file in one cycle. A long random run of legal and illegal words, with back-to-back dependent sources, covers this. A behavioural model checks every cycle of that run.

// File: rtl/opu_pkg.sv
package opu_pkg;
  localparam int INSTR_W   = 16;
  localparam int REG_SEL_W = 3;
  localparam int IMM_W     = 5;

  localparam logic [3:0] OPC_ADD = 4'b0001;
  localparam logic [3:0] OPC_AND = 4'b0101;
  localparam logic [3:0] OPC_NOT = 4'b1001;
  localparam logic [5:0] NOT_TAIL = 6'b111111;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_AND = 2'd1,
    ALU_NOT = 2'd2
  } aluOp_e;

  typedef struct packed {
    logic                 commit;
    aluOp_e               aluOp;
    logic                 useImm;
    logic [REG_SEL_W-1:0] dstSel;
    logic [REG_SEL_W-1:0] srcASel;
    logic [REG_SEL_W-1:0] srcBSel;
    logic [IMM_W-1:0]     imm;
  } opStrobe_t;
endpackage

// File: rtl/opu_ctrl.sv
module opu_ctrl
  import opu_pkg::*;
(
  input  logic               instrValid,
  input  logic [INSTR_W-1:0] instrWord,
  output opStrobe_t          strobe
);
  logic [3:0] opcode;
  logic       legal;
  aluOp_e     opSel;

  assign opcode = instrWord[15:12];

  always_comb begin
    legal = 1'b0;
    opSel = ALU_ADD;
    unique case (opcode)
      OPC_ADD: begin
        legal = 1'b1;
        opSel = ALU_ADD;
      end
      OPC_AND: begin
        legal = 1'b1;
        opSel = ALU_AND;
      end
      OPC_NOT: begin
        legal = (instrWord[5:0] == NOT_TAIL);
        opSel = ALU_NOT;
      end
      default: begin
        legal = 1'b0;
        opSel = ALU_ADD;
      end
    endcase
  end

  always_comb begin
    strobe.commit  = instrValid && legal;
    strobe.aluOp   = opSel;
    strobe.useImm  = instrWord[5] && (opSel != ALU_NOT);
    strobe.dstSel  = instrWord[11:9];
    strobe.srcASel = instrWord[8:6];
    strobe.srcBSel = instrWord[2:0];
    strobe.imm     = instrWord[IMM_W-1:0];
  end
endmodule

// File: rtl/opu_regfile.sv
module opu_regfile #(
  parameter int DATA_W = 16,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStrobe,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [DATA_W-1:0] wrValue,
  input  logic [SEL_W-1:0]  rdSelA,
  input  logic [SEL_W-1:0]  rdSelB,
  output logic [DATA_W-1:0] rdValueA,
  output logic [DATA_W-1:0] rdValueB
);
  localparam int REG_CNT = 1 << SEL_W;

  logic [REG_CNT*DATA_W-1:0] cellFlat;

  for (genvar i = 0; i < REG_CNT; i++) begin : g_cell
    logic [DATA_W-1:0] cellQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cellQ <= '0;
      end else if (wrStrobe && (wrSel == SEL_W'(i))) begin
        cellQ <= wrValue;
      end
    end
    assign cellFlat[i*DATA_W +: DATA_W] = cellQ;
  end

  assign rdValueA = cellFlat[int'(rdSelA)*DATA_W +: DATA_W];
  assign rdValueB = cellFlat[int'(rdSelB)*DATA_W +: DATA_W];
endmodule

// File: rtl/opu_datapath.sv
module opu_datapath
  import opu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  opStrobe_t            strobe,
  output logic                 wrEn,
  output logic [REG_SEL_W-1:0] wrAddr,
  output logic [DATA_W-1:0]    wrData,
  output logic                 flagN,
  output logic                 flagZ,
  output logic                 flagP
);
  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] srcA;
  logic [DATA_W-1:0] srcBReg;
  logic [DATA_W-1:0] srcB;
  logic [DATA_W-1:0] immExt;
  logic [DATA_W-1:0] result;
  logic              resNeg;
  logic              resZero;

  opu_regfile #(.DATA_W(DATA_W), .SEL_W(REG_SEL_W)) u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .wrStrobe (strobe.commit),
    .wrSel    (strobe.dstSel),
    .wrValue  (result),
    .rdSelA   (strobe.srcASel),
    .rdSelB   (strobe.srcBSel),
    .rdValueA (srcA),
    .rdValueB (srcBReg)
  );

  assign immExt = {{EXT_W{strobe.imm[IMM_W-1]}}, strobe.imm};
  assign srcB   = strobe.useImm ? immExt : srcBReg;

  always_comb begin
    unique case (strobe.aluOp)
      ALU_ADD: result = srcA + srcB;
      ALU_AND: result = srcA & srcB;
      ALU_NOT: result = ~srcA;
      default: result = srcA + srcB;
    endcase
  end

  assign resNeg  = result[DATA_W-1];
  assign resZero = (result == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrEn   <= 1'b0;
      wrAddr <= '0;
      wrData <= '0;
      flagN  <= 1'b0;
      flagZ  <= 1'b1;
      flagP  <= 1'b0;
    end else begin
      wrEn <= strobe.commit;
      if (strobe.commit) begin
        wrAddr <= strobe.dstSel;
        wrData <= result;
        flagN  <= resNeg;
        flagZ  <= resZero;
        flagP  <= !resNeg && !resZero;
      end
    end
  end

  // R7
  flags_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones({flagN, flagZ, flagP}) == 1);

  // R7
  flags_match_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (flagZ == (wrData == '0)) && (flagN == wrData[DATA_W-1]));

  // R8
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> $stable({flagN, flagZ, flagP}));
endmodule

// File: rtl/operate_unit.sv
module operate_unit
  import opu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        instrValid,
  input  logic [15:0] instrWord,
  output logic        wrEn,
  output logic [2:0]  wrAddr,
  output logic [15:0] wrData,
  output logic        flagN,
  output logic        flagZ,
  output logic        flagP
);
  opStrobe_t strobe;

  opu_ctrl u_ctrl (
    .instrValid (instrValid),
    .instrWord  (instrWord),
    .strobe     (strobe)
  );

  opu_datapath #(.DATA_W(16)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .flagN  (flagN),
    .flagZ  (flagZ),
    .flagP  (flagP)
  );

  // R9
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !instrValid |=> !wrEn);

  // R10
  add_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && instrWord[15:12] == 4'b0001) |=>
      (wrEn && wrAddr == $past(instrWord[11:9])));

  // R8
  bad_opcode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && instrWord[15:12] == 4'b0000) |=> !wrEn);
endmodule

// File: tb/operate_unit_test.sv
module operate_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [15:0] instrWord = '0;
  logic        wrEn;
  logic [2:0]  wrAddr;
  logic [15:0] wrData;
  logic        flagN, flagZ, flagP;

  int checkCount = 0;
  int failCount  = 0;

  logic [15:0] mRegs [8];
  logic [2:0]  mFlags;   // {N,Z,P}
  logic        expWr;
  logic [2:0]  expAddr;
  logic [15:0] expData;

  always #4 clk = ~clk;

  operate_unit uut (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .flagN(flagN), .flagZ(flagZ), .flagP(flagP)
  );

  task automatic check(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [2:0] classOf(input logic [15:0] v);
    if (v[15]) return 3'b100;
    if (v == 16'h0) return 3'b010;
    return 3'b001;
  endfunction

  // Drive one instruction at a falling edge, update the model, compare at the next falling edge.
  task automatic step(input string tag, input logic v, input logic [15:0] w);
    logic [15:0] a, b, res;
    logic ok;
    instrValid = v;
    instrWord  = w;
    a = mRegs[w[8:6]];
    b = w[5] ? {{11{w[4]}}, w[4:0]} : mRegs[w[2:0]];
    ok = 1'b0;
    res = '0;
    case (w[15:12])
      4'b0001: begin ok = 1'b1; res = a + b; end
      4'b0101: begin ok = 1'b1; res = a & b; end
      4'b1001: begin ok = (w[5:0] == 6'h3f); res = ~a; end
      default: ok = 1'b0;
    endcase
    expWr = v && ok;
    if (expWr) begin
      expAddr = w[11:9];
      expData = res;
      mRegs[w[11:9]] = res;
      mFlags = classOf(res);
    end
    @(negedge clk);
    check(tag, "wrEn", {15'b0, wrEn}, {15'b0, expWr});
    if (expWr) begin
      check(tag, "wrAddr", {13'b0, wrAddr}, {13'b0, expAddr});
      check(tag, "wrData", wrData, expData);
    end
    check(tag, "flags", {13'b0, flagN, flagZ, flagP}, {13'b0, mFlags});
  endtask

  function automatic logic [15:0] addImm(input int d, input int s, input int imm);
    return {4'b0001, 3'(d), 3'(s), 1'b1, 5'(imm)};
  endfunction
  function automatic logic [15:0] addReg(input int d, input int s, input int t);
    return {4'b0001, 3'(d), 3'(s), 3'b000, 3'(t)};
  endfunction

  initial begin
    #(8 * 150000);
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checkCount, failCount);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) mRegs[i] = '0;
    mFlags = 3'b010;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check("R1", "wrEn in reset", {15'b0, wrEn}, 16'h0);
    check("R1", "flags in reset", {13'b0, flagN, flagZ, flagP}, 16'h2);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "flags after reset", {13'b0, flagN, flagZ, flagP}, 16'h2);
    // R1: every register reads zero
    for (int i = 0; i < 8; i++) step("R1", 1'b1, addImm(i, i, 0));

    // R4 / R7: negative immediate, negative flag
    step("R4", 1'b1, addImm(1, 0, -1));
    step("R4", 1'b1, addImm(2, 0, 15));
    // R3: register add with wrap, bits [4:3] set are ignored
    step("R3", 1'b1, addReg(3, 1, 2));
    step("R3", 1'b1, {4'b0001, 3'd4, 3'd2, 3'b011, 3'd2});
    // R5: AND register and immediate
    step("R5", 1'b1, {4'b0101, 3'd4, 3'd1, 3'b000, 3'd2});
    step("R5", 1'b1, {4'b0101, 3'd6, 3'd1, 1'b1, 5'b10000});
    // R6: inversion
    step("R6", 1'b1, {4'b1001, 3'd5, 3'd2, 6'h3f});
    // R7: zero and positive results
    step("R7", 1'b1, addImm(7, 2, -15));
    step("R7", 1'b1, addImm(0, 2, -16));
    step("R7", 1'b1, addImm(0, 2, 1));
    // R8: illegal inversion, then read back destination
    step("R8", 1'b1, {4'b1001, 3'd5, 3'd1, 6'h3e});
    step("R8", 1'b1, addImm(5, 5, 0));
    // R8: unknown opcodes
    step("R8", 1'b1, {4'b0010, 3'd2, 9'h1ff});
    step("R8", 1'b1, {4'b0000, 3'd2, 9'h0ff});
    step("R8", 1'b1, addImm(2, 2, 0));
    // R9: valid low with a legal instruction
    step("R9", 1'b0, addImm(3, 0, 0));
    step("R9", 1'b1, addImm(3, 3, 0));
    // R2: field positions, distinct dst/src
    step("R2", 1'b1, addReg(6, 5, 3));
    // R10: back-to-back dependent chain
    step("R10", 1'b1, addImm(4, 4, 1));
    step("R10", 1'b1, addImm(4, 4, 1));
    step("R10", 1'b1, addReg(4, 4, 4));
    // R10: random mix
    for (int k = 0; k < 400; k++) begin
      logic [15:0] w;
      int sel;
      w = 16'($urandom);
      sel = $urandom_range(0, 9);
      if (sel < 3) w[15:12] = 4'b0001;
      else if (sel < 5) w[15:12] = 4'b0101;
      else if (sel < 7) begin w[15:12] = 4'b1001; if (sel == 6) w[5:0] = 6'h3f; end
      step("R10", ($urandom_range(0, 7) != 0), w);
    end
    instrValid = 1'b0;
    @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", checkCount, failCount);
    $finish;
  end
endmodule